// File: doc/BRIEF.md
# Chainable Priority Encoder

This block resolves a bank of active-low request lines to the binary index of the most important one. It is built from identical eight-input slices. Each slice takes active-low requests and an active-low enable. It returns an active-low index, an active-low group flag that shows it found a request, and an active-low enable output. That enable output passes permission down to the next, less important slice only when the slice itself is enabled and sees no request.

The top level chains slices from the most important downward. It then rebuilds one active-high result from the slices' outputs. The low index bits are the inverted AND of every slice's active-low index. The high bits name the slice whose group flag is low. A single active-high flag tells whether any request won. With the default of two slices, this gives a sixteen-input encoder with a four-bit code. In that encoder, line 15 has the highest priority and line 0 the lowest.

The block is purely combinational. It has no clock and no reset, and it holds no state. The slice count and the slice width are parameters.

Top module: `prio_enc_cascade`

## Requirements
- R1: With `en_n` low and exactly one request line `req_n[i]` low, `code` equals i, `any_req` is 1 and `eo_n` is 1.
- R2: With `en_n` low and several request lines low, `code` equals the largest index among them. Bit 15 wins over every other bit.
- R3: When any line in the upper slice (bits 15..8) is low, `code[3]` is 1. The state of lines 7..0 then has no effect on `code`.
- R4: With `en_n` low and all request lines high, `code` is 0, `any_req` is 0 and `eo_n` is 0.
- R5: With `en_n` high, `code` is 0, `any_req` is 0 and `eo_n` is 1, whatever the request lines are.
- R6: `eo_n` is 0 only when `en_n` is 0 and every request line is 1.
- R7: `any_req` is 1 exactly when `en_n` is 0 and at least one request line is 0. When `any_req` is 0, `code` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_n | input | SLICE_W*SLICES (16) | Active-low requests. A higher index has higher priority. |
| en_n | input | 1 | Active-low enable of the whole chain. |
| code | output | $clog2(SLICES)+$clog2(SLICE_W) (4) | Active-high index of the winning request. |
| any_req | output | 1 | Active-high flag: some request is granted. |
| eo_n | output | 1 | Active-low enable output, for a further lower-priority stage. |

## Verification
The bench goes after the slice boundary: lines 8 and 7 at once, and patterns where lines in both halves are low. A chain that failed to disable the lower slice would OR a lower index into `code[2:0]` and produce a wrong, mixed code.

The all-high and disabled cases are checked separately. A design that confused the two would drive `eo_n` the wrong way, or raise `any_req` while disabled.

Every single-bit and every two-bit pattern is applied, along with random multi-bit patterns. These catch a reversed priority order or a wrong inversion on any index bit.

// File: rtl/pe_scan.sv
module pe_scan #(
    parameter int W = 8,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  hit,
    output logic [IW-1:0] pos,
    output logic          found
);
    // the highest-index hit wins: later iterations overwrite earlier ones
    always_comb begin
        pos   = '0;
        found = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (hit[i]) begin
                pos   = IW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pe_slice.sv
module pe_slice #(
    parameter int W = 8,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  req_n,
    input  logic          ei_n,
    output logic [IW-1:0] a_n,
    output logic          gs_n,
    output logic          eo_n
);
    logic [IW-1:0] pos;
    logic          found;
    logic          active;

    pe_scan #(.W(W)) u_scan (
        .hit   (~req_n),
        .pos   (pos),
        .found (found)
    );

    assign active = ~ei_n;

    always_comb begin
        if (active && found) begin
            a_n  = ~pos;
            gs_n = 1'b0;
            eo_n = 1'b1;
        end else begin
            a_n  = '1;
            gs_n = 1'b1;
            eo_n = ~active;   // low only when enabled and idle
        end
    end
endmodule

// File: rtl/pe_merge.sv
module pe_merge #(
    parameter int SLICES = 2,
    parameter int IW     = 3,
    localparam int SW    = $clog2(SLICES),
    localparam int CW    = SW + IW
) (
    input  logic [SLICES*IW-1:0] a_n_all,
    input  logic [SLICES-1:0]    gs_n_all,
    output logic [CW-1:0]        code,
    output logic                 any_req
);
    logic [IW-1:0] low_bits;
    logic [SW-1:0] slice_id;

    always_comb begin
        low_bits = '1;
        slice_id = '0;
        for (int k = 0; k < SLICES; k++) begin
            low_bits = low_bits & a_n_all[k*IW +: IW];
            if (!gs_n_all[k]) slice_id = slice_id | SW'(k);
        end
    end

    assign code    = {slice_id, ~low_bits};
    assign any_req = ~&gs_n_all;
endmodule

// File: rtl/prio_enc_cascade.sv
module prio_enc_cascade #(
    parameter int SLICE_W = 8,
    parameter int SLICES  = 2,
    localparam int IW     = $clog2(SLICE_W),
    localparam int SW     = $clog2(SLICES),
    localparam int N      = SLICE_W * SLICES,
    localparam int CW     = SW + IW
) (
    input  logic [N-1:0]  req_n,
    input  logic          en_n,
    output logic [CW-1:0] code,
    output logic          any_req,
    output logic          eo_n
);
    logic [SLICES:0]       chain_n;
    logic [SLICES*IW-1:0]  a_n_all;
    logic [SLICES-1:0]     gs_n_all;

    // the most important slice receives the external enable
    assign chain_n[SLICES] = en_n;

    for (genvar k = 0; k < SLICES; k++) begin : g_slice
        pe_slice #(.W(SLICE_W)) u_slice (
            .req_n (req_n[k*SLICE_W +: SLICE_W]),
            .ei_n  (chain_n[k+1]),
            .a_n   (a_n_all[k*IW +: IW]),
            .gs_n  (gs_n_all[k]),
            .eo_n  (chain_n[k])
        );
    end

    pe_merge #(.SLICES(SLICES), .IW(IW)) u_merge (
        .a_n_all  (a_n_all),
        .gs_n_all (gs_n_all),
        .code     (code),
        .any_req  (any_req)
    );

    assign eo_n = chain_n[0];
endmodule

// File: rtl/prio_enc_cascade_chk.sv
module prio_enc_cascade_chk #(
    parameter int N  = 16,
    parameter int CW = 4
) (
    input logic [N-1:0]  req_n,
    input logic          en_n,
    input logic [CW-1:0] code,
    input logic          any_req,
    input logic          eo_n
);
    logic [N-1:0] above;
    always_comb above = (~req_n) >> code;

    always_comb begin
        if (!$isunknown({req_n, en_n, code, any_req, eo_n})) begin
            assert_disabled_quiet_R5: assert (!en_n || (code == '0 && !any_req && eo_n))
                else $error("disabled chain not quiet");
            assert_eo_only_idle_R6: assert (eo_n || (!en_n && &req_n))
                else $error("eo_n low with a request or while disabled");
            assert_any_matches_R7: assert (any_req == (!en_n && !(&req_n)))
                else $error("any_req disagrees with requests");
            assert_idle_code_zero_R4: assert (any_req || code == '0)
                else $error("code nonzero while idle");
            assert_winner_requested_R1: assert (!any_req || !req_n[code])
                else $error("coded line is not requesting");
            assert_nothing_higher_R2: assert (!any_req || above == N'(1))
                else $error("a higher line was requesting");
        end
    end
endmodule

bind prio_enc_cascade prio_enc_cascade_chk #(.N(N), .CW(CW)) u_chk (
    .req_n   (req_n),
    .en_n    (en_n),
    .code    (code),
    .any_req (any_req),
    .eo_n    (eo_n)
);

// File: tb/prio_enc_cascade_test.sv
module prio_enc_cascade_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;
    localparam int NV = 16;

    logic         clk = 1'b0;
    logic [N-1:0] req_n = '1;
    logic         en_n = 1'b0;
    logic [3:0]   code;
    logic         any_req;
    logic         eo_n;
    int           applied = 0;
    int           failed = 0;
    bit           done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_enc_cascade uut (
        .req_n   (req_n),
        .en_n    (en_n),
        .code    (code),
        .any_req (any_req),
        .eo_n    (eo_n)
    );

    // {req_n, en_n, code, any_req, eo_n, tag}
    localparam logic [26:0] TABLE [NV] = '{
        {16'hFFFF, 1'b0, 4'd0,  1'b0, 1'b0, 4'd4}, // R4 idle
        {16'hFFFE, 1'b0, 4'd0,  1'b1, 1'b1, 4'd1}, // R1 line 0
        {16'hFFFD, 1'b0, 4'd1,  1'b1, 1'b1, 4'd1}, // R1 line 1
        {16'hFFFB, 1'b0, 4'd2,  1'b1, 1'b1, 4'd1}, // R1 line 2
        {16'hFF7F, 1'b0, 4'd7,  1'b1, 1'b1, 4'd1}, // R1 line 7
        {16'hFEFF, 1'b0, 4'd8,  1'b1, 1'b1, 4'd1}, // R1 line 8
        {16'hFDFF, 1'b0, 4'd9,  1'b1, 1'b1, 4'd1}, // R1 line 9
        {16'h7FFF, 1'b0, 4'd15, 1'b1, 1'b1, 4'd1}, // R1 line 15
        {16'h0000, 1'b0, 4'd15, 1'b1, 1'b1, 4'd2}, // R2 all low
        {16'hFF00, 1'b0, 4'd7,  1'b1, 1'b1, 4'd2}, // R2 lower half
        {16'hFE7F, 1'b0, 4'd8,  1'b1, 1'b1, 4'd3}, // R3 lines 8 and 7
        {16'h7FFE, 1'b0, 4'd15, 1'b1, 1'b1, 4'd3}, // R3 lines 15 and 0
        {16'hEFF7, 1'b0, 4'd12, 1'b1, 1'b1, 4'd3}, // R3 lines 12 and 3
        {16'h0000, 1'b1, 4'd0,  1'b0, 1'b1, 4'd5}, // R5 disabled, all low
        {16'hFFFF, 1'b1, 4'd0,  1'b0, 1'b1, 4'd6}, // R6 disabled idle keeps eo_n high
        {16'hFF3C, 1'b0, 4'd7,  1'b1, 1'b1, 4'd7}  // R7 mixed
    };

    // Reference from the requirements: scan from the top line downward.
    function automatic logic [5:0] expect_of(input logic [N-1:0] r, input logic e);
        logic [3:0] c;
        logic       a;
        c = '0;
        a = 1'b0;
        if (!e) begin
            for (int i = N-1; i >= 0; i--) begin
                if (!a && !r[i]) begin
                    c = 4'(i);
                    a = 1'b1;
                end
            end
        end
        return {c, a, !(!e && !a)};
    endfunction

    task automatic apply(input logic [N-1:0] r, input logic e,
                         input logic [5:0] exp, input int tag);
        @(negedge clk);
        req_n = r;
        en_n  = e;
        #(CLK_PERIOD/4);
        applied++;
        if ({code, any_req, eo_n} !== exp) begin
            failed++;
            $display("FAIL R%0d req_n=%h en_n=%b got code=%0d any=%b eo_n=%b exp code=%0d any=%b eo_n=%b",
                     tag, r, e, code, any_req, eo_n, exp[5:2], exp[1], exp[0]);
        end
    endtask

    initial begin
        #(CLK_PERIOD*200000);
        if (!done) begin
            failed++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
            $finish;
        end
    end

    initial begin
        // idle state after start: R4 and R6
        apply('1, 1'b0, {4'd0, 1'b0, 1'b0}, 4);

        for (int v = 0; v < NV; v++)
            apply(TABLE[v][26:11], TABLE[v][10], TABLE[v][9:4], int'(TABLE[v][3:0]));

        // R1 every single line, enabled; R5 same patterns disabled
        for (int i = 0; i < N; i++) begin
            apply(~(16'd1 << i), 1'b0, {4'(i), 1'b1, 1'b1}, 1);
            apply(~(16'd1 << i), 1'b1, {4'd0, 1'b0, 1'b1}, 5);
        end

        // R2 and R3 every pair of lines
        for (int i = 0; i < N; i++)
            for (int j = 0; j < i; j++)
                apply(~((16'd1 << i) | (16'd1 << j)), 1'b0,
                      {4'(i), 1'b1, 1'b1}, (i >= 8 && j < 8) ? 3 : 2);

        // R3: upper line fixed, lower half varied, code must not move
        for (int k = 0; k < 256; k++)
            apply({8'hDF, 8'(k)}, 1'b0, {4'd13, 1'b1, 1'b1}, 3);

        // R7 and R6 random multi-bit patterns
        for (int k = 0; k < 2000; k++) begin
            logic [N-1:0] r;
            logic         e;
            r = N'($urandom);
            if (k % 7 == 0) r = r | N'($urandom);
            e = ($urandom % 8) == 0;
            apply(r, e, expect_of(r, e), 7);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
        $finish;
    end
endmodule